// File: doc/BRIEF.md
# Two-Wire Bus Receive Front End with Broadcast Sync Address

This block is the bus-facing half of a write-only peripheral on a two-wire serial bus (I2C-style). A system clock at least eight times faster than the bus clock oversamples the bus. The block passes both lines through synchronisers and finds clock edges and START and STOP conditions. It shifts in bytes with the most significant bit first, and it decides from the first byte of each transfer whether to take part in it. The block never transmits data. Its only effect on the bus is an open-drain acknowledge, given by pulling the data line low.

The block answers two addresses. The first is its own address: a fixed upper nibble followed by three strap pins, with a write direction bit. The second is a broadcast sync address that several devices share. For the sync address, the eighth bit is a command flag rather than a direction bit, and the transfer ends after one acknowledge. At the rising clock edge of that acknowledge, the block emits a one-cycle pulse that carries the flag. All devices on the bus therefore see the same edge, and they can all apply staged settings or clear them at the same time.

Downstream logic receives START and STOP events, the sync pulse and a stream of received data bytes, each tagged with its position in the transfer. The byte stream has a valid strobe but no ready input. Without clock stretching the bus cannot be held back, so the consumer must take each byte in the single cycle in which it is valid.

Top module: `twi_rx_front`

## Requirements
- R1: A falling data line while the clock line is high gives a one-cycle `start_o` pulse. A rising data line while the clock line is high gives a one-cycle `stop_o` pulse. These pulses appear in every state.
- R2: The own address is the 7-bit value {4'b0100, `strap_i[2:0]`}. A first byte of {own address, 0} is acknowledged. A first byte of {own address, 1} is not acknowledged, and neither is any first byte whose upper seven bits match no known address.
- R3: The acknowledge is given by asserting `sda_pull_o` (1 = pull the data line low). It goes high after the clock falls at the end of the eighth bit, stays steady through the whole high phase of the ninth clock, and goes low after the ninth clock falls.
- R4: After the own address is acknowledged, every later byte is acknowledged. Each byte is also presented once on `byte_data_o`, most significant bit first, with `byte_valid_o` high for one cycle. `byte_idx_o` gives the byte's position, counting from 0 for the first byte after the address.
- R5: The sync address 7'b1111110 is acknowledged whatever its eighth bit. On the ninth rising clock edge of that transfer, `sync_pulse_o` pulses for one cycle while the clock line is still high, and `sync_flag_o` carries the eighth bit.
- R6: After a not-acknowledged address, or after the acknowledge of the sync address, the block does nothing further until the next START or STOP. It gives no acknowledge and emits no bytes.
- R7: A repeated START at any point discards any partly received byte and restarts address decoding. The byte index of the next data byte is 0 again.
- R8: While reset is held, and after it is released with the bus idle, all outputs are 0.
- R9: No two of `start_o`, `stop_o`, `byte_valid_o` and `sync_pulse_o` are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| strap_i | input | 3 | Low three bits of the own address |
| sda_pull_o | output | 1 | 1 = pull the data line low (acknowledge) |
| start_o | output | 1 | START or repeated START seen |
| stop_o | output | 1 | STOP seen |
| byte_valid_o | output | 1 | Received data byte valid (no back-pressure) |
| byte_data_o | output | 8 | Received data byte |
| byte_idx_o | output | IDX_W | Position of the byte in the transfer |
| sync_pulse_o | output | 1 | Sync acknowledge clock edge |
| sync_flag_o | output | 1 | Flag bit that came with the sync address |

## Verification
The hardest case to reach from the ports is a repeated START that arrives in the middle of a byte, after the transfer has already advanced its byte index. To get there, the bench sends two data bytes, clocks out half of another address, and issues a START while the clock is high. It then checks that the next data byte comes out with index 0. The second hard case is traffic that follows a sync acknowledge without a new START. The bench reaches it by sending a full own-address byte straight after the sync acknowledge and checking that no acknowledge and no byte appear.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SYNC,
    ST_IGNORE
  } rx_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_i,
  output logic [LANES-1:0] sync_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;

  // R9
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise_o, scl_fall_o, start_o, stop_o}));
endmodule

// File: rtl/twi_rx_engine.sv
module twi_rx_engine
  import twi_rx_pkg::*;
#(
  parameter int         IDX_W     = 4,
  parameter logic [3:0] OWN_HI    = 4'b0100,
  parameter logic [6:0] SYNC_ADDR = 7'b1111110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s_i,
  input  logic              scl_s_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  output logic              ack_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              sync_pulse_o,
  output logic              sync_flag_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_HIGH = CNT_W'(BYTE_W + 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] shift_q;
  logic [BYTE_W-1:0] next_byte;
  logic [6:0]        own_addr;
  logic              active;

  assign next_byte = {shift_q, sda_s_i};
  assign own_addr  = {OWN_HI, strap_i};
  assign active    = (state_q == ST_ADDR) || (state_q == ST_DATA) || (state_q == ST_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      shift_q      <= '0;
      ack_o        <= 1'b0;
      start_o      <= 1'b0;
      stop_o       <= 1'b0;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
      byte_idx_o   <= '0;
      sync_pulse_o <= 1'b0;
      sync_flag_o  <= 1'b0;
    end else begin
      start_o      <= start_i;
      stop_o       <= stop_i;
      byte_valid_o <= 1'b0;
      sync_pulse_o <= 1'b0;
      if (byte_valid_o) byte_idx_o <= byte_idx_o + 1'b1;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        ack_o   <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        ack_o   <= 1'b0;
      end else if (active) begin
        if (rise_i) begin
          if (cnt_q < ACK_SLOT) begin
            shift_q <= next_byte[BYTE_W-2:0];
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              if (state_q == ST_ADDR) begin
                if (next_byte[7:1] == own_addr && !next_byte[0]) begin
                  state_q    <= ST_DATA;
                  byte_idx_o <= '0;
                end else if (next_byte[7:1] == SYNC_ADDR) begin
                  state_q     <= ST_SYNC;
                  sync_flag_o <= next_byte[0];
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else if (state_q == ST_DATA) begin
                byte_valid_o <= 1'b1;
                byte_data_o  <= next_byte;
              end
            end
          end else if (cnt_q == ACK_SLOT) begin
            cnt_q <= ACK_HIGH;
            if (state_q == ST_SYNC) sync_pulse_o <= 1'b1;
          end
        end else if (fall_i) begin
          if (cnt_q == ACK_SLOT) begin
            ack_o <= 1'b1;
          end else if (cnt_q == ACK_HIGH) begin
            ack_o <= 1'b0;
            cnt_q <= '0;
            if (state_q == ST_SYNC) state_q <= ST_IGNORE;
          end
        end
      end
    end
  end

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s_i && !fall_i && !rise_i && !start_i && !stop_i) |=> $stable(ack_o));
  // R5
  sync_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse_o |-> ack_o);
  // R6
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> (!ack_o && !byte_valid_o));
  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o);
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ACK_HIGH);
  // R9
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, byte_valid_o, sync_pulse_o}));
endmodule

// File: rtl/twi_rx_front.sv
module twi_rx_front
  import twi_rx_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         IDX_W       = 4,
  parameter logic [3:0] OWN_HI      = 4'b0100,
  parameter logic [6:0] SYNC_ADDR   = 7'b1111110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_pull_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              sync_pulse_o,
  output logic              sync_flag_o
);
  logic [1:0] lines_s;
  logic       rise, fall, start_ev, stop_ev;

  twi_line_sync #(.LANES(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({scl_i, sda_i}),
    .sync_o  (lines_s)
  );

  twi_cond_detect det_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s_i    (lines_s[1]),
    .sda_s_i    (lines_s[0]),
    .scl_rise_o (rise),
    .scl_fall_o (fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  twi_rx_engine #(.IDX_W(IDX_W), .OWN_HI(OWN_HI), .SYNC_ADDR(SYNC_ADDR)) eng_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_s_i      (lines_s[0]),
    .scl_s_i      (lines_s[1]),
    .rise_i       (rise),
    .fall_i       (fall),
    .start_i      (start_ev),
    .stop_i       (stop_ev),
    .strap_i      (strap_i),
    .ack_o        (sda_pull_o),
    .start_o      (start_o),
    .stop_o       (stop_o),
    .byte_valid_o (byte_valid_o),
    .byte_data_o  (byte_data_o),
    .byte_idx_o   (byte_idx_o),
    .sync_pulse_o (sync_pulse_o),
    .sync_flag_o  (sync_flag_o)
  );
endmodule

// File: tb/twi_rx_front_tb.sv
module twi_rx_front_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_pull, start_o, stop_o, bv, sp, sf;
  logic [7:0] bd;
  logic [3:0] bidx;
  wire        bus_sda = sda_drv & ~sda_pull;

  always #2 clk = ~clk;

  twi_rx_front dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda), .strap_i(strap),
    .sda_pull_o(sda_pull), .start_o(start_o), .stop_o(stop_o),
    .byte_valid_o(bv), .byte_data_o(bd), .byte_idx_o(bidx),
    .sync_pulse_o(sp), .sync_flag_o(sf)
  );

  int checks = 0, fails = 0;
  int n_start = 0, n_stop = 0, n_byte = 0, n_sync = 0;
  logic [7:0] cap_d [32];
  logic [3:0] cap_i [32];
  logic last_flag = 1'b0, sync_scl_ok = 1'b1;

  // {address byte, data count, d0, d1, d2}
  localparam logic [39:0] VEC [7] = '{
    {8'h4A, 8'd3, 8'h03, 8'hFF, 8'h02},
    {8'h4A, 8'd1, 8'h5A, 8'h00, 8'h00},
    {8'h4B, 8'd1, 8'h66, 8'h00, 8'h00},
    {8'h4C, 8'd2, 8'h4A, 8'h99, 8'h00},
    {8'hFD, 8'd0, 8'h00, 8'h00, 8'h00},
    {8'hFC, 8'd0, 8'h00, 8'h00, 8'h00},
    {8'h4A, 8'd0, 8'h00, 8'h00, 8'h00}
  };

  always @(negedge clk) begin
    if (start_o) n_start++;
    if (stop_o)  n_stop++;
    if (bv) begin
      cap_d[n_byte % 32] = bd;
      cap_i[n_byte % 32] = bidx;
      n_byte++;
    end
    if (sp) begin
      n_sync++;
      last_flag = sf;
      if (!scl) sync_scl_ok = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    w(4); sda_drv = 1'b1; w(4); scl = 1'b1; w(4); sda_drv = 1'b0; w(4); scl = 1'b0;
  endtask

  task automatic bus_stop;
    w(4); sda_drv = 1'b0; w(4); scl = 1'b1; w(4); sda_drv = 1'b1; w(8);
  endtask

  task automatic send_bit(input logic b);
    w(4); sda_drv = b; w(4); scl = 1'b1; w(8); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, output bit rel);
    bit pre, mid, late;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    w(4); sda_drv = 1'b1; w(3); pre = sda_pull; w(1); scl = 1'b1;
    w(4); mid = !bus_sda; w(3); late = !bus_sda; w(1); scl = 1'b0;
    w(6); rel = !sda_pull;
    ack = pre && mid && late;
  endtask

  initial begin
    bit ack, rel;
    int s0, p0, b0, y0;
    logic [7:0] a;
    int n;
    bit own, syn;
    w(3);
    // R8: outputs while reset held
    chk({sda_pull, start_o, stop_o, bv, sp, sf} == 6'b0, "R8 in reset", {sda_pull, start_o, stop_o, bv, sp, sf}, 0);
    rst_n = 1'b1;
    w(10);
    chk({sda_pull, start_o, stop_o, bv, sp, sf, bd, bidx} == '0, "R8 after reset", {sda_pull, bv, sp}, 0);

    for (int v = 0; v < 7; v++) begin
      a = VEC[v][39:32];
      n = int'(VEC[v][31:24]);
      own = (a[7:1] == {4'b0100, strap}) && !a[0];
      syn = (a[7:1] == 7'b1111110);
      s0 = n_start; p0 = n_stop; b0 = n_byte; y0 = n_sync;
      bus_start();
      send_byte(a, ack, rel);
      chk(ack == (own || syn), "R2 address acknowledge", ack, own || syn);
      chk(!ack || rel, "R3 release after ninth clock", rel, 1);
      for (int k = 0; k < n; k++) begin
        send_byte(VEC[v][23-8*k -: 8], ack, rel);
        chk(ack == own, own ? "R4 data acknowledge" : "R6 ignored byte not acknowledged", ack, own);
      end
      bus_stop();
      chk(n_start - s0 == 1 && n_stop - p0 == 1, "R1 start/stop events", (n_start - s0) * 16 + (n_stop - p0), 17);
      chk(n_byte - b0 == (own ? n : 0), own ? "R4 byte count" : "R6 no bytes", n_byte - b0, own ? n : 0);
      if (own)
        for (int k = 0; k < n; k++)
          chk(cap_d[(b0 + k) % 32] == VEC[v][23-8*k -: 8] && cap_i[(b0 + k) % 32] == 4'(k),
              "R4 byte data/index", {cap_d[(b0 + k) % 32], cap_i[(b0 + k) % 32]}, {VEC[v][23-8*k -: 8], 4'(k)});
      chk(n_sync - y0 == (syn ? 1 : 0), "R5 sync pulse count", n_sync - y0, syn ? 1 : 0);
      if (syn) chk(last_flag == a[0] && sync_scl_ok, "R5 sync flag and edge", {last_flag, sync_scl_ok}, {a[0], 1'b1});
    end

    // R6: traffic after the sync acknowledge without a new START
    b0 = n_byte;
    bus_start();
    send_byte(8'hFD, ack, rel);
    chk(ack, "R5 sync acknowledged", ack, 1);
    send_byte(8'h4A, ack, rel);
    chk(!ack, "R6 no acknowledge after sync", ack, 0);
    send_byte(8'h12, ack, rel);
    chk(!ack && n_byte == b0, "R6 no byte after sync", n_byte - b0, 0);
    bus_stop();

    // R7: repeated START mid-byte resets the index
    b0 = n_byte; s0 = n_start;
    bus_start();
    send_byte(8'h4A, ack, rel);
    send_byte(8'h11, ack, rel);
    send_byte(8'h22, ack, rel);
    for (int i = 7; i >= 4; i--) send_bit(1'(8'h4A >> i));
    bus_start();
    send_byte(8'h4A, ack, rel);
    chk(ack, "R7 address after repeated start", ack, 1);
    send_byte(8'h33, ack, rel);
    bus_stop();
    chk(n_start - s0 == 2, "R7 repeated start event", n_start - s0, 2);
    chk(n_byte - b0 == 3, "R7 byte count", n_byte - b0, 3);
    chk(cap_d[(b0 + 2) % 32] == 8'h33 && cap_i[(b0 + 2) % 32] == 4'd0, "R7 index restarts at 0",
        {cap_d[(b0 + 2) % 32], cap_i[(b0 + 2) % 32]}, {8'h33, 4'd0});
    chk(cap_i[(b0 + 1) % 32] == 4'd1, "R4 second index", cap_i[(b0 + 1) % 32], 1);

    // R2: strap pins select the low address bits
    strap = 3'b000;
    w(4);
    b0 = n_byte;
    bus_start();
    send_byte(8'h40, ack, rel);
    chk(ack, "R2 strapped address 0x20 write", ack, 1);
    send_byte(8'h77, ack, rel);
    bus_stop();
    chk(n_byte - b0 == 1 && cap_d[b0 % 32] == 8'h77, "R4 byte under new strap", cap_d[b0 % 32], 8'h77);
    bus_start();
    send_byte(8'h4A, ack, rel);
    chk(!ack, "R2 old address rejected", ack, 0);
    bus_stop();
    chk(!sda_pull && !bv, "R8 idle outputs", {sda_pull, bv}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule